// File: doc/BRIEF.md
# Wraparound-Triggered Bank Switch Detector

This block watches a 16-bit address, 8-bit data processor bus, taking one sample per qualified bus cycle. It picks which 64 KB RAM bank the whole address space maps to, and it has no register mapped into that space. Software switches banks by letting execution run off the top of memory into address zero. The read at the top address puts whatever byte is on the data bus into a staging latch. If the next qualified cycle is a read of address zero, that byte becomes the new bank. If the next cycle is anything else, the staged byte is dropped.

The bank output drives the upper RAM address lines. A new bank takes effect in the cycle after the address-zero read, so that read still goes to the old bank.

A hardening mode can be enabled. In that mode a commit also requires that the cycle just before the top-address read was a read of byte 0x80 from the address one below the top. This makes an accidental switch even less likely.

A one-cycle flag marks every cycle in which the bank value has just changed.

Top module: `bank_wrap_sw`

## Requirements
- R1: After reset, `bank_o` is 0, `bank_upd_o` is 0 and no value is staged, so a read of address 0x0000 as the first cycle leaves the bank at 0.
- R2: A qualified read (`cyc_vld_i`=1, `rnw_i`=1) of address 0xFFFF stages `data_i`. If the next qualified cycle is a read of 0x0000, `bank_o` takes the staged value from the cycle after that read, and keeps the old value during the read itself.
- R3: If the qualified cycle after the 0xFFFF read is anything other than a read of 0x0000, the staged value is discarded. The bank is unchanged, and a later read of 0x0000 commits nothing.
- R4: Write cycles (`rnw_i`=0) at 0xFFFF or 0x0000 never stage or commit a bank value. A write at 0x0000 right after a staging read also discards the staged value.
- R5: Cycles with `cyc_vld_i`=0 are ignored. They change no state and do not count as the "next cycle" of the sequence.
- R6: When `harden_i`=1 during the 0xFFFF read, a commit also requires that the previous qualified cycle was a read of byte 0x80 from 0xFFFE.
- R7: With hardening on, a preceding read of 0xFFFE with any byte other than 0x80, a read of 0x80 from any other address, or a write of 0x80 to 0xFFFE all prevent the commit.
- R8: `bank_upd_o` is high for exactly one cycle, the first cycle `bank_o` shows a new value. It stays low when a commit loads the value the bank already holds.
- R9: Back-to-back 0xFFFF reads restage, so the last one's byte is committed. With hardening on, the second read fails the check, because its preceding cycle was not the 0x80 read of 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_vld_i | input | 1 | Qualifies the current bus cycle |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Bus data |
| harden_i | input | 1 | Enables the preceding-cycle check |
| bank_o | output | 8 | Selected 64 KB bank |
| bank_upd_o | output | 1 | One-cycle pulse on a bank change |

## Verification
The basic wrap sequence is tried clean and then with each kind of interruption, to separate a real commit from a stale or discarded stage:
- an unrelated read between the two halves;
- writes at either end of the sequence;
- unqualified cycles that present address zero.

Hardening is tried with:
- the correct 0x80 read of 0xFFFE;
- the right address with the wrong byte;
- the right byte at the wrong address;
- a write of 0x80 to 0xFFFE.

These show that the address, the data and the direction are each required. Repeated top-address reads and recommits of the current bank separate restaging from latching, and a real change from a mere commit in the update pulse.

// File: rtl/bank_wrap_pkg.sv
package bank_wrap_pkg;
  typedef struct packed {
    logic top;   // address all-ones
    logic zero;  // address all-zeros
    logic pre;   // address one below top
  } addr_hit_t;
endpackage

// File: rtl/bank_wrap_match.sv
module bank_wrap_match
  import bank_wrap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output addr_hit_t         hit_o
);
  localparam logic [ADDR_W-1:0] TOP_A = '1;
  localparam logic [ADDR_W-1:0] PRE_A = TOP_A - 1'b1;

  always_comb begin
    hit_o.top  = (addr_i == TOP_A);
    hit_o.zero = (addr_i == '0);
    hit_o.pre  = (addr_i == PRE_A);
  end
endmodule

// File: rtl/bank_wrap_stage.sv
module bank_wrap_stage #(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  HDR_CODE = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_vld_i,
  input  logic              rd_i,
  input  logic              top_i,
  input  logic              pre_i,
  input  logic              harden_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] stg_data_o,
  output logic              stg_arm_o
);
  logic hdr_seen_q, stg_vld_q, stg_ok_q;
  logic [DATA_W-1:0] stg_q;
  logic hdr_now;

  assign hdr_now = rd_i && pre_i && (data_i == DATA_W'(HDR_CODE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_seen_q <= 1'b0;
      stg_vld_q  <= 1'b0;
      stg_ok_q   <= 1'b0;
      stg_q      <= '0;
    end else if (cyc_vld_i) begin
      hdr_seen_q <= hdr_now;
      if (rd_i && top_i) begin
        stg_q     <= data_i;
        stg_vld_q <= 1'b1;
        stg_ok_q  <= !harden_i || hdr_seen_q;
      end else begin
        stg_vld_q <= 1'b0;
      end
    end
  end

  assign stg_data_o = stg_q;
  assign stg_arm_o  = stg_vld_q && stg_ok_q;

  AST_STAGE_ON_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_vld_i && rd_i && top_i) |=> (stg_vld_q && stg_q == $past(data_i))); // R2
  AST_HARDEN_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_vld_i && rd_i && top_i && harden_i && !hdr_seen_q) |=> !stg_arm_o); // R6
  AST_IDLE_HOLDS_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_vld_i |=> ($stable(stg_vld_q) && $stable(stg_q))); // R5
endmodule

// File: rtl/bank_wrap_reg.sv
module bank_wrap_reg #(
  parameter int BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [BANK_W-1:0] new_bank_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              upd_o
);
  logic [BANK_W-1:0] bank_q;
  logic upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= commit_i && (new_bank_i != bank_q);
      if (commit_i) bank_q <= new_bank_i;
    end
  end

  assign bank_o = bank_q;
  assign upd_o  = upd_q;

  AST_PULSE_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (bank_q != $past(bank_q))); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> (!upd_q || !$stable(bank_q))); // R8
endmodule

// File: rtl/bank_wrap_sw.sv
module bank_wrap_sw
  import bank_wrap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_vld_i,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              harden_i,
  output logic [DATA_W-1:0] bank_o,
  output logic              bank_upd_o
);
  addr_hit_t hit;
  logic [DATA_W-1:0] stg_data;
  logic stg_arm, commit;

  bank_wrap_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_i(addr_i), .hit_o(hit)
  );

  bank_wrap_stage #(.DATA_W(DATA_W)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_vld_i(cyc_vld_i), .rd_i(rnw_i),
    .top_i(hit.top), .pre_i(hit.pre), .harden_i(harden_i), .data_i(data_i),
    .stg_data_o(stg_data), .stg_arm_o(stg_arm)
  );

  assign commit = cyc_vld_i && rnw_i && hit.zero && stg_arm;

  bank_wrap_reg #(.BANK_W(DATA_W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .new_bank_i(stg_data),
    .bank_o(bank_o), .upd_o(bank_upd_o)
  );

  AST_ZERO_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_vld_i && rnw_i && addr_i == '0) |=> $stable(bank_o)); // R3
  AST_WRITE_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_vld_i && !rnw_i) |=> $stable(bank_o)); // R4
  AST_IDLE_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_vld_i |=> ($stable(bank_o) && !bank_upd_o)); // R5
endmodule

// File: tb/sim_bank_wrap_sw.sv
`timescale 1ns/1ps
module sim_bank_wrap_sw;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_vld = 1'b0, rnw = 1'b1, harden = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [7:0]  bank;
  logic        upd;
  int n_chk = 0, n_bad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  bank_wrap_sw u0 (
    .clk_i(clk), .rst_ni(rst_n), .cyc_vld_i(cyc_vld), .rnw_i(rnw),
    .addr_i(addr), .data_i(data), .harden_i(harden),
    .bank_o(bank), .bank_upd_o(upd)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drv(logic [15:0] a, logic [7:0] d, logic r, logic v);
    @(negedge clk);
    addr = a; data = d; rnw = r; cyc_vld = v;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] d = 8'h00);
    drv(a, d, 1'b1, 1'b1); step();
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    drv(a, d, 1'b0, 1'b1); step();
  endtask

  task automatic idle(logic [15:0] a);
    drv(a, 8'h00, 1'b1, 1'b0); step();
  endtask

  task automatic t_reset();
    chk("R1 bank", bank, 8'h00);
    chk("R1 upd", {7'b0, upd}, 8'h00);
    rd(16'h0000);
    chk("R1 no stage", bank, 8'h00);
  endtask

  task automatic t_basic();
    rd(16'hFFFF, 8'h05);
    drv(16'h0000, 8'h00, 1'b1, 1'b1);
    #1 chk("R2 old during zero read", bank, 8'h00);
    step();
    chk("R2 new bank", bank, 8'h05);
    chk("R8 pulse", {7'b0, upd}, 8'h01);
    rd(16'h1000);
    chk("R8 pulse ends", {7'b0, upd}, 8'h00);
  endtask

  task automatic t_discard();
    rd(16'hFFFF, 8'h09); rd(16'h1234); rd(16'h0000);
    chk("R3 discard", bank, 8'h05);
  endtask

  task automatic t_write();
    wr(16'hFFFF, 8'h0A); rd(16'h0000);
    chk("R4 write top", bank, 8'h05);
    rd(16'hFFFF, 8'h0B); wr(16'h0000, 8'h0B);
    chk("R4 write zero", bank, 8'h05);
    rd(16'h0000);
    chk("R4 discarded after write", bank, 8'h05);
  endtask

  task automatic t_idle();
    rd(16'hFFFF, 8'h0C); idle(16'h0000); idle(16'h0000);
    chk("R5 idle no commit", bank, 8'h05);
    chk("R5 idle no pulse", {7'b0, upd}, 8'h00);
    rd(16'h0000);
    chk("R5 commit across idle", bank, 8'h0C);
  endtask

  task automatic t_same();
    rd(16'hFFFF, 8'h0C); rd(16'h0000);
    chk("R8 same value", bank, 8'h0C);
    chk("R8 no pulse", {7'b0, upd}, 8'h00);
  endtask

  task automatic t_harden();
    harden = 1'b1;
    rd(16'hFFFF, 8'h20); rd(16'h0000);
    chk("R6 no prefix", bank, 8'h0C);
    rd(16'hFFFE, 8'h80); rd(16'hFFFF, 8'h21); rd(16'h0000);
    chk("R6 prefix ok", bank, 8'h21);
    rd(16'hFFFE, 8'h81); rd(16'hFFFF, 8'h22); rd(16'h0000);
    chk("R7 wrong byte", bank, 8'h21);
    rd(16'hFFFD, 8'h80); rd(16'hFFFF, 8'h23); rd(16'h0000);
    chk("R7 wrong addr", bank, 8'h21);
    wr(16'hFFFE, 8'h80); rd(16'hFFFF, 8'h24); rd(16'h0000);
    chk("R7 write prefix", bank, 8'h21);
    harden = 1'b0;
  endtask

  task automatic t_double();
    rd(16'hFFFF, 8'h30); rd(16'hFFFF, 8'h31); rd(16'h0000);
    chk("R9 restage", bank, 8'h31);
    harden = 1'b1;
    rd(16'hFFFE, 8'h80); rd(16'hFFFF, 8'h40); rd(16'hFFFF, 8'h41); rd(16'h0000);
    chk("R9 hardened restage", bank, 8'h31);
    harden = 1'b0;
  endtask

  initial begin
    #2 chk("R1 bank in reset", bank, 8'h00);
    #55 rst_n = 1'b1;
    step();
    t_reset(); t_basic(); t_discard(); t_write();
    t_idle(); t_same(); t_harden(); t_double();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule